// File: doc/BRIEF.md
# Oversampled Test Access Port Controller

This block is a boundary-scan test access port controller that lives entirely in the system clock domain. The serial test clock, mode-select and data-in lines arrive as asynchronous inputs. Each passes through a two-flop synchronizer, and the block turns the synchronized test clock into single-cycle rising-edge and falling-edge pulses. The test clock never clocks a flop. The system clock must run at least eight times faster than the test clock.

On every detected rising edge, the controller steps its sixteen-state machine according to the synchronized mode-select value. In the capture, shift and update states of the instruction path it drives a 3-bit instruction register. It also owns a 1-bit pass-through data register. The serial output and its output enable change only on detected falling edges. An external data register attaches through three one-cycle strobes (capture, shift and update of the data path), the current state and the decoded instruction, and it supplies its own serial bit when it is selected.

Top module: `jtag_os_tap`

## Requirements
- R1: After `rst_ni` is low, `state_o` reads 0 (Test-Logic-Reset), `instr_o` reads 3'b111 (pass-through code), and `tdo_oe_o` and `tdo_o` read 0.
- R2: On each test-clock rising edge, with the test clock at up to 1/8 of `clk_i`, `state_o` takes the standard next state chosen by `tms_i`. The state codes are: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R3: Five consecutive rising edges with `tms_i` high bring the controller to state 0 from any state, and it stays in state 0 while `tms_i` stays high.
- R4: One rising edge with `tms_i` low in state 0 moves the controller to state 1. Three further rising edges with `tms_i` high return it to state 0, passing through states 2 and 9.
- R5: While the test clock is held low, `state_o`, `instr_o`, `tdo_o` and `tdo_oe_o` stay unchanged, whatever `tms_i` and `tdi_i` do.
- R6: A rising edge in capture-IR loads the instruction shift register with 3'b001. Each rising edge in shift-IR shifts it right, with `tdi_i` entering at bit 2 and bit 0 presented on `tdo_o`, so the shift is least significant bit first. A rising edge in update-IR copies the shift register to `instr_o`.
- R7: `tdo_o` and `tdo_oe_o` change only on test-clock falling edges. `tdo_oe_o` goes high only when the state at that falling edge is shift-IR or shift-DR, and it is 0 after a falling edge in any other state.
- R8: The pass-through bit captures 0 on a rising edge in capture-DR and loads `tdi_i` on each rising edge in shift-DR. With instruction 3'b111, `tdo_o` shows that bit in shift-DR, so data emerges delayed by one test clock.
- R9: `capture_dr_o`, `shift_dr_o` and `update_dr_o` each pulse for one `clk_i` cycle on a rising edge taken in capture-DR, shift-DR and update-DR respectively.
- R10: In shift-DR, when `ext_sel_i` is high and the instruction is not 3'b111, `tdo_o` takes `ext_tdo_i` as sampled at the falling edge. Otherwise it takes the pass-through bit.
- R11: Entering state 0 forces `instr_o` back to 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the test clock |
| rst_ni | input | 1 | Active-low power-on reset |
| tck_i | input | 1 | Asynchronous test clock |
| tms_i | input | 1 | Asynchronous mode select |
| tdi_i | input | 1 | Asynchronous serial data in |
| tdo_o | output | 1 | Serial data out |
| tdo_oe_o | output | 1 | Output enable for tdo_o |
| state_o | output | 4 | Current controller state code |
| instr_o | output | 3 | Active instruction |
| capture_dr_o | output | 1 | Data-path capture strobe |
| shift_dr_o | output | 1 | Data-path shift strobe |
| update_dr_o | output | 1 | Data-path update strobe |
| ext_sel_i | input | 1 | External data register claims the instruction |
| ext_tdo_i | input | 1 | Serial bit from the external data register |

## Verification
On every cycle the assertions check the following. The edge pulses and strobes last one cycle. State and instruction hold when no rising edge arrives. The serial output moves only on falling edges. The output enable rises only in the shift states. Reset forces the pass-through instruction. Five high mode-select edges always reach reset. The bench scenarios are needed to show the exact state walk through all sixteen codes, the stray-edge recovery, the LSB-first order of captured and shifted bits, the one-clock delay of the pass-through path, the selection of the external source, and the retention of every output while the test clock is held low, at both the 1:8 ratio and slower ratios.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET    = 4'd0,
        TS_IDLE     = 4'd1,
        TS_DR_SEL   = 4'd2,
        TS_DR_CAP   = 4'd3,
        TS_DR_SHIFT = 4'd4,
        TS_DR_EXIT1 = 4'd5,
        TS_DR_PAUSE = 4'd6,
        TS_DR_EXIT2 = 4'd7,
        TS_DR_UPD   = 4'd8,
        TS_IR_SEL   = 4'd9,
        TS_IR_CAP   = 4'd10,
        TS_IR_SHIFT = 4'd11,
        TS_IR_EXIT1 = 4'd12,
        TS_IR_PAUSE = 4'd13,
        TS_IR_EXIT2 = 4'd14,
        TS_IR_UPD   = 4'd15
    } tap_state_e;

    // Next state of the controller for one mode-select sample.
    function automatic tap_state_e tap_step(input tap_state_e cur, input logic m);
        tap_state_e nxt;
        case (cur)
            TS_RESET:    nxt = m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   nxt = m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   nxt = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: nxt = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: nxt = m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: nxt = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: nxt = m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   nxt = m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   nxt = m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   nxt = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: nxt = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: nxt = m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: nxt = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: nxt = m ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   nxt = m ? TS_DR_SEL   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
        return nxt;
    endfunction

    function automatic logic tap_is_shift(input tap_state_e cur);
        return (cur == TS_IR_SHIFT) || (cur == TS_DR_SHIFT);
    endfunction

endpackage

// File: rtl/tap_sync_edge.sv
module tap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tck_i,
    input  logic tms_i,
    input  logic tdi_i,
    output logic tck_rise_o,
    output logic tck_fall_o,
    output logic tms_o,
    output logic tdi_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] tck;
        logic [STAGES-1:0] tms;
        logic [STAGES-1:0] tdi;
        logic              tck_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.tck      = {q.tck[TOP-1:0], tck_i};
        d.tms      = {q.tms[TOP-1:0], tms_i};
        d.tdi      = {q.tdi[TOP-1:0], tdi_i};
        d.tck_last = q.tck[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tck_rise_o = q.tck[TOP] & ~q.tck_last;
    assign tck_fall_o = ~q.tck[TOP] & q.tck_last;
    assign tms_o      = q.tms[TOP];
    assign tdi_o      = q.tdi[TOP];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tck_rise_o |=> !tck_rise_o); // R2
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tck_fall_o |=> !tck_fall_o); // R7

endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tck_rise_i,
    input  logic       tms_i,
    output tap_state_e state_o
);

    tap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (tck_rise_i) begin
            state_d = tap_step(state_q, tms_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // Checker-side count of consecutive high mode-select edges, saturating at five.
    logic [2:0] hi_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run_q <= 3'd0;
        end else if (tck_rise_i) begin
            if (!tms_i) begin
                hi_run_q <= 3'd0;
            end else if (hi_run_q != 3'd5) begin
                hi_run_q <= hi_run_q + 3'd1;
            end
        end
    end

    AST_FIVE_HIGH_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_run_q == 3'd5) |-> (state_q == TS_RESET)); // R3
    AST_STAY_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tck_rise_i && tms_i && state_q == TS_RESET) |=> (state_q == TS_RESET)); // R3
    AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tck_rise_i |=> $stable(state_q)); // R5

endmodule

// File: rtl/tap_regs.sv
module tap_regs
    import tap_pkg::*;
#(
    parameter int              IR_W        = 3,
    parameter logic [IR_W-1:0] CAPTURE_PAT = 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tck_rise_i,
    input  logic            tck_fall_i,
    input  tap_state_e      state_i,
    input  logic            tdi_i,
    input  logic            ext_sel_i,
    input  logic            ext_tdo_i,
    output logic [IR_W-1:0] instr_o,
    output logic            tdo_o,
    output logic            tdo_oe_o
);

    localparam logic [IR_W-1:0] BYPASS_CODE = '1;

    typedef struct packed {
        logic [IR_W-1:0] ir_sh;
        logic [IR_W-1:0] ir;
        logic            byp;
        logic            tdo;
        logic            oe;
    } regs_t;

    regs_t q, d;
    logic  ext_active;

    assign ext_active = ext_sel_i && (q.ir != BYPASS_CODE);

    always_comb begin
        d = q;
        if (tck_rise_i) begin
            case (state_i)
                TS_IR_CAP:   d.ir_sh = CAPTURE_PAT;
                TS_IR_SHIFT: d.ir_sh = {tdi_i, q.ir_sh[IR_W-1:1]};
                TS_IR_UPD:   d.ir    = q.ir_sh;
                TS_DR_CAP:   d.byp   = 1'b0;
                TS_DR_SHIFT: d.byp   = tdi_i;
                default:     ;
            endcase
        end
        if (state_i == TS_RESET) begin
            d.ir = BYPASS_CODE;
        end
        if (tck_fall_i) begin
            d.oe = tap_is_shift(state_i);
            case (state_i)
                TS_IR_SHIFT: d.tdo = q.ir_sh[0];
                TS_DR_SHIFT: d.tdo = ext_active ? ext_tdo_i : q.byp;
                default:     d.tdo = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.ir_sh <= CAPTURE_PAT;
            q.ir    <= BYPASS_CODE;
            q.byp   <= 1'b0;
            q.tdo   <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign instr_o  = q.ir;
    assign tdo_o    = q.tdo;
    assign tdo_oe_o = q.oe;

    AST_TDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tck_fall_i |=> ($stable(tdo_o) && $stable(tdo_oe_o))); // R7
    AST_OE_SHIFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tdo_oe_o) |-> tap_is_shift(state_i)); // R7
    AST_RESET_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == TS_RESET) |=> (instr_o == BYPASS_CODE)); // R11
    AST_INSTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tck_rise_i && state_i != TS_RESET) |=> $stable(instr_o)); // R5

endmodule

// File: rtl/jtag_os_tap.sv
module jtag_os_tap
    import tap_pkg::*;
#(
    parameter int              IR_W        = 3,
    parameter int              SYNC_STAGES = 2,
    parameter logic [IR_W-1:0] CAPTURE_PAT = 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tck_i,
    input  logic            tms_i,
    input  logic            tdi_i,
    output logic            tdo_o,
    output logic            tdo_oe_o,
    output logic [3:0]      state_o,
    output logic [IR_W-1:0] instr_o,
    output logic            capture_dr_o,
    output logic            shift_dr_o,
    output logic            update_dr_o,
    input  logic            ext_sel_i,
    input  logic            ext_tdo_i
);

    logic       tck_rise, tck_fall, tms_s, tdi_s;
    tap_state_e state;

    tap_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tck_i      (tck_i),
        .tms_i      (tms_i),
        .tdi_i      (tdi_i),
        .tck_rise_o (tck_rise),
        .tck_fall_o (tck_fall),
        .tms_o      (tms_s),
        .tdi_o      (tdi_s)
    );

    tap_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tck_rise_i (tck_rise),
        .tms_i      (tms_s),
        .state_o    (state)
    );

    tap_regs #(
        .IR_W        (IR_W),
        .CAPTURE_PAT (CAPTURE_PAT)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tck_rise_i (tck_rise),
        .tck_fall_i (tck_fall),
        .state_i    (state),
        .tdi_i      (tdi_s),
        .ext_sel_i  (ext_sel_i),
        .ext_tdo_i  (ext_tdo_i),
        .instr_o    (instr_o),
        .tdo_o      (tdo_o),
        .tdo_oe_o   (tdo_oe_o)
    );

    assign state_o      = state;
    assign capture_dr_o = tck_rise && (state == TS_DR_CAP);
    assign shift_dr_o   = tck_rise && (state == TS_DR_SHIFT);
    assign update_dr_o  = tck_rise && (state == TS_DR_UPD);

    AST_CAPTURE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_dr_o |=> (!capture_dr_o && state_o != 4'd3)); // R9
    AST_SHIFT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_dr_o |=> !shift_dr_o); // R9
    AST_UPDATE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        update_dr_o |=> (!update_dr_o && state_o != 4'd8)); // R9

endmodule

// File: tb/jtag_os_tap_tb_top.sv
module jtag_os_tap_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic ext_sel = 1'b0, ext_tdo = 1'b0;
    logic tdo, tdo_oe, cap_dr, sh_dr, up_dr;
    logic [3:0] state;
    logic [2:0] instr;

    int checks = 0;
    int errors = 0;
    int cap_cnt = 0, sh_cnt = 0, up_cnt = 0;

    always #10 clk = ~clk;

    jtag_os_tap dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tck_i        (tck),
        .tms_i        (tms),
        .tdi_i        (tdi),
        .tdo_o        (tdo),
        .tdo_oe_o     (tdo_oe),
        .state_o      (state),
        .instr_o      (instr),
        .capture_dr_o (cap_dr),
        .shift_dr_o   (sh_dr),
        .update_dr_o  (up_dr),
        .ext_sel_i    (ext_sel),
        .ext_tdo_i    (ext_tdo)
    );

    always_ff @(posedge clk) begin
        if (cap_dr) cap_cnt <= cap_cnt + 1;
        if (sh_dr)  sh_cnt  <= sh_cnt + 1;
        if (up_dr)  up_cnt  <= up_cnt + 1;
    end

    // {half period in clk cycles, tms, expected state after the edge}
    localparam logic [8:0] WALK [26] = '{
        {4'd4, 1'b0, 4'd1},  {4'd6, 1'b0, 4'd1},  {4'd4, 1'b1, 4'd2},
        {4'd6, 1'b0, 4'd3},  {4'd4, 1'b1, 4'd5},  {4'd6, 1'b0, 4'd6},
        {4'd4, 1'b0, 4'd6},  {4'd6, 1'b1, 4'd7},  {4'd4, 1'b0, 4'd4},
        {4'd6, 1'b0, 4'd4},  {4'd4, 1'b1, 4'd5},  {4'd6, 1'b1, 4'd8},
        {4'd4, 1'b1, 4'd2},  {4'd6, 1'b1, 4'd9},  {4'd4, 1'b0, 4'd10},
        {4'd6, 1'b1, 4'd12}, {4'd4, 1'b0, 4'd13}, {4'd6, 1'b1, 4'd14},
        {4'd4, 1'b0, 4'd11}, {4'd6, 1'b1, 4'd12}, {4'd4, 1'b1, 4'd15},
        {4'd6, 1'b1, 4'd2},  {4'd4, 1'b1, 4'd9},  {4'd6, 1'b1, 4'd0},
        {4'd4, 1'b1, 4'd0},  {4'd6, 1'b0, 4'd1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One test-clock period of 2*half system clocks; returns half-1 clocks after the fall.
    task automatic tck_cycle(input logic m, input logic d, input int half);
        tms = m;
        tdi = d;
        @(negedge clk);
        tck = 1'b1;
        repeat (half) @(negedge clk);
        tck = 1'b0;
        repeat (half - 1) @(negedge clk);
    endtask

    // From idle: load an instruction, collect the bits shifted out, return to idle.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        seen[0] = tdo;
        check("R7 oe in shift-IR", {7'd0, tdo_oe}, 8'd1);
        for (int i = 0; i < 3; i++) begin
            tck_cycle(i == 2, code[i], 4);
            if (i < 2) seen[i+1] = tdo;
        end
        check("R7 oe after shift-IR", {7'd0, tdo_oe}, 8'd0);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2:0] seen;
        logic [3:0] st_h;
        logic [2:0] ir_h;
        logic       tdo_h, oe_h;
        int c0, s0, u0;

        // R1 reset state
        repeat (5) @(negedge clk);
        check("R1 state", {4'd0, state}, 8'd0);
        check("R1 instr", {5'd0, instr}, 8'd7);
        check("R1 oe", {7'd0, tdo_oe}, 8'd0);
        check("R1 tdo", {7'd0, tdo}, 8'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 table walk through all sixteen states at 1:8 and 1:12
        for (int i = 0; i < 26; i++) begin
            tck_cycle(WALK[i][4], 1'b0, int'(WALK[i][8:5]));
            check("R2 walk", {4'd0, state}, {4'd0, WALK[i][3:0]});
        end

        // R3 five high edges from every state reached by a walk prefix
        for (int k = 0; k < 26; k++) begin
            for (int j = 0; j < 5; j++) tck_cycle(1'b1, 1'b0, 4);
            for (int i = 0; i <= k; i++) tck_cycle(WALK[i][4], 1'b0, 4);
            for (int j = 0; j < 5; j++) tck_cycle(1'b1, 1'b0, (k % 2) ? 5 : 4);
            check("R3 five high", {4'd0, state}, 8'd0);
        end
        for (int j = 0; j < 4; j++) tck_cycle(1'b1, 1'b0, 4);
        check("R3 stay reset", {4'd0, state}, 8'd0);

        // R4 stray low then three highs
        tck_cycle(1'b0, 1'b0, 4);
        check("R4 stray idle", {4'd0, state}, 8'd1);
        tck_cycle(1'b1, 1'b0, 4);
        check("R4 step 1", {4'd0, state}, 8'd2);
        tck_cycle(1'b1, 1'b0, 4);
        check("R4 step 2", {4'd0, state}, 8'd9);
        tck_cycle(1'b1, 1'b0, 4);
        check("R4 back to reset", {4'd0, state}, 8'd0);

        // R6 instruction load, capture pattern shifted out LSB first
        tck_cycle(1'b0, 1'b0, 4);
        load_ir(3'b010, seen);
        check("R6 captured bits", {5'd0, seen}, 8'd1);
        check("R6 instr loaded", {5'd0, instr}, 8'd2);
        check("R2 idle after update", {4'd0, state}, 8'd1);

        // R10 external register selected
        ext_sel = 1'b1;
        ext_tdo = 1'b1;
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        check("R10 ext bit 1", {7'd0, tdo}, 8'd1);
        ext_tdo = 1'b0;
        tck_cycle(1'b0, 1'b1, 4);
        check("R10 ext bit 0", {7'd0, tdo}, 8'd0);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        ext_sel = 1'b0;

        // R11 reset state restores the pass-through code
        for (int j = 0; j < 5; j++) tck_cycle(1'b1, 1'b0, 4);
        check("R11 instr bypass", {5'd0, instr}, 8'd7);
        tck_cycle(1'b0, 1'b0, 4);

        // R8 / R9 pass-through scan with ext_sel low
        c0 = cap_cnt; s0 = sh_cnt; u0 = up_cnt;
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        tck_cycle(1'b0, 1'b1, 4);
        check("R8 captured zero", {7'd0, tdo}, 8'd0);
        check("R7 oe in shift-DR", {7'd0, tdo_oe}, 8'd1);
        tck_cycle(1'b0, 1'b1, 7);
        check("R8 delayed one", {7'd0, tdo}, 8'd1);
        tck_cycle(1'b0, 1'b0, 4);
        check("R8 delayed zero", {7'd0, tdo}, 8'd0);
        tck_cycle(1'b1, 1'b1, 4);
        check("R7 oe off in exit", {7'd0, tdo_oe}, 8'd0);
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        check("R9 capture strobes", 8'(cap_cnt - c0), 8'd1);
        check("R9 shift strobes", 8'(sh_cnt - s0), 8'd3);
        check("R9 update strobes", 8'(up_cnt - u0), 8'd1);

        // R5 hold with the test clock stopped low inside shift-DR
        tck_cycle(1'b1, 1'b0, 4);
        tck_cycle(1'b0, 1'b0, 4);
        tck_cycle(1'b0, 1'b1, 4);
        repeat (4) @(negedge clk);
        st_h = state; ir_h = instr; tdo_h = tdo; oe_h = tdo_oe;
        for (int j = 0; j < 300; j++) begin
            tms = j[0];
            tdi = j[1];
            @(negedge clk);
        end
        check("R5 state held", {4'd0, state}, {4'd0, st_h});
        check("R5 instr held", {5'd0, instr}, {5'd0, ir_h});
        check("R5 tdo held", {7'd0, tdo}, {7'd0, tdo_h});
        check("R5 oe held", {7'd0, tdo_oe}, {7'd0, oe_h});

        finish_run();
    end

endmodule